// File: doc/BRIEF.md
# Inset Picture Window and Border Generator

This block decides, pel by pel, what the inset picture contributes to the main raster. It compares the main pixel and line counters, which are referenced to main sync, with a window whose origin comes from two 6-bit position codes and whose size comes from a size select. The window consists of a picture area surrounded by a coloured frame. The block outputs 6-bit luma and two 6-bit chroma values, together with a flag that marks the pels where the inset replaces the main picture.

Inside the picture area the block passes through the samples read from field memory, or it substitutes a solid test colour. The frame takes its colour from an 8-entry palette, and two palette codes make the frame transparent. A blank control turns the whole window black, and this has priority over every other setting. Outside the window the outputs sit at reference levels so that the clamps further down the path settle correctly. If the window would reach into the guard zone before main sync, it is suppressed for the whole field.

Every pel passes through one register stage. Each pel is classified into one of three regions: `RG_OUTSIDE`, `RG_FRAME` and `RG_PICTURE`. The region register loads the classification on every clock; there are no other transitions. The output process then picks the colour for the registered region. Defaults: 768 pels per line, 256 lines per field, a horizontal guard of 40 pels and a vertical guard of 6 lines.

Top module: `pip_overlay_gen`

## Requirements
- R1: During reset and on the first sample after it, outputs are Y=0, U=32, V=32 with win_active=0.
- R2: Outputs appear one clock after the counter and sample inputs. In the picture area with blank=0 and fill=00, the outputs equal the memory samples and win_active=1.
- R3: size_large=1 gives a picture of 114 pels by 71 lines; size_large=0 gives 84 pels by 53 lines. A frame 3 pels wide lies on the left and right, and a frame 2 lines tall lies above and below. The outer origin is the window start.
- R4: The window starts at pel x_code*12 and line y_code*4 (line length/64 and field height/64).
- R5: Frame colours for frame_sel (Y,U,V) are: 000 black (0,32,32), 001 dim white (44,32,32), 100 blue (18,56,28), 101 green (36,12,10), 110 red (20,22,56), 111 white (63,32,32).
- R6: frame_sel 010 and 011 make the frame transparent: frame pels give win_active=0 with reference levels.
- R7: In the picture area, fill_sel 01, 10 and 11 replace the samples with green, blue and red, using the palette values of R5.
- R8: win_blank=1 makes every pel of the outer window (0,32,32) with win_active=1, whatever the frame and fill settings are.
- R9: win_enable=0 gives no window anywhere.
- R10: Every pel outside the window gives Y=0, U=32, V=32 and win_active=0.
- R11: If the outer right edge exceeds pel 728, or the outer bottom edge exceeds line 250, the window is off everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pel clock |
| rst_n | input | 1 | Active-low reset |
| pix_cnt | input | 10 | Main pixel counter |
| line_cnt | input | 8 | Main line counter |
| x_code | input | 6 | Horizontal start code |
| y_code | input | 6 | Vertical start code |
| size_large | input | 1 | 1 selects the large window |
| win_enable | input | 1 | Show window |
| win_blank | input | 1 | Force window black |
| frame_sel | input | 3 | Frame colour code |
| fill_sel | input | 2 | Solid fill code |
| mem_y | input | 6 | Luma sample from memory |
| mem_u | input | 6 | U sample from memory |
| mem_v | input | 6 | V sample from memory |
| out_y | output | 6 | Luma out |
| out_u | output | 6 | U out |
| out_v | output | 6 | V out |
| win_active | output | 1 | Inset replaces main picture |

## Verification
The hardest cases to reach are the exact first and last pels of the frame and of the picture area, and position codes that lie just on either side of the guard cutoff. Uniformly random counters would almost never land on these. The stimulus therefore first picks the position codes. It then computes the window edges and places the counters within a few pels and lines of those edges. Directed cases cover the cutoff codes (50/51 and 43/44 for the large size) and every frame and fill code.

// File: rtl/pip_ovl_pkg.sv
package pip_ovl_pkg;
    localparam int SW  = 6;
    localparam logic [SW-1:0] MID = 6'd32;

    typedef struct packed {
        logic [SW-1:0] y;
        logic [SW-1:0] u;
        logic [SW-1:0] v;
    } pel_t;

    typedef enum logic [1:0] {
        RG_OUTSIDE = 2'd0,
        RG_FRAME   = 2'd1,
        RG_PICTURE = 2'd2
    } region_t;

    localparam pel_t C_BLACK = '{y: 6'd0,  u: 6'd32, v: 6'd32};
    localparam pel_t C_DIM   = '{y: 6'd44, u: 6'd32, v: 6'd32};
    localparam pel_t C_WHITE = '{y: 6'd63, u: 6'd32, v: 6'd32};
    localparam pel_t C_BLUE  = '{y: 6'd18, u: 6'd56, v: 6'd28};
    localparam pel_t C_GREEN = '{y: 6'd36, u: 6'd12, v: 6'd10};
    localparam pel_t C_RED   = '{y: 6'd20, u: 6'd22, v: 6'd56};

    function automatic pel_t frame_colour(input logic [2:0] code);
        pel_t c;
        unique case (code)
            3'b000:  c = C_BLACK;
            3'b001:  c = C_DIM;
            3'b100:  c = C_BLUE;
            3'b101:  c = C_GREEN;
            3'b110:  c = C_RED;
            3'b111:  c = C_WHITE;
            default: c = C_BLACK;
        endcase
        return c;
    endfunction

    function automatic pel_t fill_colour(input logic [1:0] code);
        pel_t c;
        unique case (code)
            2'b01:   c = C_GREEN;
            2'b10:   c = C_BLUE;
            default: c = C_RED;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/pip_ovl_geom.sv
module pip_ovl_geom
    import pip_ovl_pkg::*;
#(
    parameter int LINE_PELS   = 768,
    parameter int FIELD_LINES = 256,
    parameter int H_GUARD     = 40,
    parameter int V_GUARD     = 6,
    parameter int PIX_W       = 10,
    parameter int LIN_W       = 8
) (
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic [LIN_W-1:0] line_cnt,
    input  logic [5:0]       x_code,
    input  logic [5:0]       y_code,
    input  logic             size_large,
    input  logic             win_enable,
    output logic             guard_cut,
    output region_t          region
);
    localparam int H_STEP  = LINE_PELS / 64;
    localparam int V_STEP  = FIELD_LINES / 64;
    localparam int FRM_H   = 3;
    localparam int FRM_V   = 2;
    localparam int BIG_W   = 114;
    localparam int BIG_H   = 71;
    localparam int SML_W   = 84;
    localparam int SML_H   = 53;
    localparam int H_LIMIT = LINE_PELS - H_GUARD;
    localparam int V_LIMIT = FIELD_LINES - V_GUARD;

    int xs, ys, pw, ph, ow, oh, px, ln;
    logic in_outer, in_pic;

    always_comb begin
        xs = int'(x_code) * H_STEP;
        ys = int'(y_code) * V_STEP;
        pw = size_large ? BIG_W : SML_W;
        ph = size_large ? BIG_H : SML_H;
        ow = pw + 2 * FRM_H;
        oh = ph + 2 * FRM_V;
        px = int'(pix_cnt);
        ln = int'(line_cnt);
        guard_cut = (xs + ow > H_LIMIT) || (ys + oh > V_LIMIT);
        in_outer  = (px >= xs) && (px < xs + ow) && (ln >= ys) && (ln < ys + oh);
        in_pic    = (px >= xs + FRM_H) && (px < xs + FRM_H + pw) &&
                    (ln >= ys + FRM_V) && (ln < ys + FRM_V + ph);
        if (!win_enable || guard_cut || !in_outer) region = RG_OUTSIDE;
        else if (in_pic)                           region = RG_PICTURE;
        else                                       region = RG_FRAME;
    end
endmodule

// File: rtl/pip_ovl_colour.sv
module pip_ovl_colour
    import pip_ovl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  region_t     region_in,
    input  logic        win_blank,
    input  logic [2:0]  frame_sel,
    input  logic [1:0]  fill_sel,
    input  pel_t        sample_in,
    output pel_t        pel_out,
    output logic        win_active
);
    region_t    rg_q;
    logic       blank_q;
    logic [2:0] frame_q;
    logic [1:0] fill_q;
    pel_t       sample_q;

    // state register: region of the pel now on the outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q     <= RG_OUTSIDE;
            blank_q  <= 1'b0;
            frame_q  <= 3'b000;
            fill_q   <= 2'b00;
            sample_q <= C_BLACK;
        end else begin
            rg_q     <= region_in;
            blank_q  <= win_blank;
            frame_q  <= frame_sel;
            fill_q   <= fill_sel;
            sample_q <= sample_in;
        end
    end

    logic frame_clear;
    assign frame_clear = (frame_q[2:1] == 2'b01);

    // outputs from the registered region
    always_comb begin
        pel_out    = C_BLACK;
        win_active = 1'b0;
        unique case (rg_q)
            RG_OUTSIDE: begin
                pel_out    = C_BLACK;
                win_active = 1'b0;
            end
            RG_FRAME: begin
                if (blank_q) begin
                    pel_out    = C_BLACK;
                    win_active = 1'b1;
                end else if (frame_clear) begin
                    pel_out    = C_BLACK;
                    win_active = 1'b0;
                end else begin
                    pel_out    = frame_colour(frame_q);
                    win_active = 1'b1;
                end
            end
            RG_PICTURE: begin
                win_active = 1'b1;
                if (blank_q)             pel_out = C_BLACK;
                else if (fill_q != 2'b00) pel_out = fill_colour(fill_q);
                else                      pel_out = sample_q;
            end
            default: begin
                pel_out    = C_BLACK;
                win_active = 1'b0;
            end
        endcase
    end

    // R10
    outside_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |-> (pel_out.y == 6'd0 && pel_out.u == MID && pel_out.v == MID));
endmodule

// File: rtl/pip_overlay_gen.sv
module pip_overlay_gen
    import pip_ovl_pkg::*;
#(
    parameter int LINE_PELS   = 768,
    parameter int FIELD_LINES = 256,
    parameter int H_GUARD     = 40,
    parameter int V_GUARD     = 6,
    parameter int PIX_W       = $clog2(LINE_PELS),
    parameter int LIN_W       = $clog2(FIELD_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic [LIN_W-1:0] line_cnt,
    input  logic [5:0]       x_code,
    input  logic [5:0]       y_code,
    input  logic             size_large,
    input  logic             win_enable,
    input  logic             win_blank,
    input  logic [2:0]       frame_sel,
    input  logic [1:0]       fill_sel,
    input  logic [5:0]       mem_y,
    input  logic [5:0]       mem_u,
    input  logic [5:0]       mem_v,
    output logic [5:0]       out_y,
    output logic [5:0]       out_u,
    output logic [5:0]       out_v,
    output logic             win_active
);
    region_t region;
    logic    guard_cut;
    pel_t    sample, pel;

    assign sample = '{y: mem_y, u: mem_u, v: mem_v};

    pip_ovl_geom #(
        .LINE_PELS(LINE_PELS), .FIELD_LINES(FIELD_LINES),
        .H_GUARD(H_GUARD), .V_GUARD(V_GUARD),
        .PIX_W(PIX_W), .LIN_W(LIN_W)
    ) u_geom (
        .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .x_code(x_code), .y_code(y_code),
        .size_large(size_large), .win_enable(win_enable),
        .guard_cut(guard_cut), .region(region)
    );

    pip_ovl_colour u_colour (
        .clk(clk), .rst_n(rst_n), .region_in(region),
        .win_blank(win_blank), .frame_sel(frame_sel), .fill_sel(fill_sel),
        .sample_in(sample), .pel_out(pel), .win_active(win_active)
    );

    assign out_y = pel.y;
    assign out_u = pel.u;
    assign out_v = pel.v;

    // R11
    guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        guard_cut |=> !win_active);
    // R9
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_enable |=> !win_active);
    // R8
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_blank && region != RG_OUTSIDE) |=> (win_active && out_y == 6'd0));
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_PICTURE && !win_blank && fill_sel == 2'b00) |=>
        (out_y == $past(mem_y) && out_u == $past(mem_u) && out_v == $past(mem_v)));
endmodule

// File: tb/pip_overlay_gen_test.sv
module pip_overlay_gen_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [9:0] pix_cnt = '0;
    logic [7:0] line_cnt = '0;
    logic [5:0] x_code = '0, y_code = '0;
    logic size_large = 1'b0, win_enable = 1'b0, win_blank = 1'b0;
    logic [2:0] frame_sel = '0;
    logic [1:0] fill_sel = '0;
    logic [5:0] mem_y = '0, mem_u = '0, mem_v = '0;
    logic [5:0] out_y, out_u, out_v;
    logic win_active;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pip_overlay_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
        .x_code(x_code), .y_code(y_code), .size_large(size_large),
        .win_enable(win_enable), .win_blank(win_blank), .frame_sel(frame_sel),
        .fill_sel(fill_sel), .mem_y(mem_y), .mem_u(mem_u), .mem_v(mem_v),
        .out_y(out_y), .out_u(out_u), .out_v(out_v), .win_active(win_active)
    );

    // expected {active, y, u, v}
    function automatic logic [18:0] model();
        int xs, ys, pw, ph, ow, oh, px, ln;
        bit outer, pic;
        logic [17:0] ref_c;
        ref_c = {6'd0, 6'd32, 6'd32};
        xs = x_code * 12; ys = y_code * 4;
        pw = size_large ? 114 : 84; ph = size_large ? 71 : 53;
        ow = pw + 6; oh = ph + 4;
        px = pix_cnt; ln = line_cnt;
        outer = px >= xs && px < xs + ow && ln >= ys && ln < ys + oh;
        pic = px >= xs + 3 && px < xs + 3 + pw && ln >= ys + 2 && ln < ys + 2 + ph;
        if (!win_enable || xs + ow > 728 || ys + oh > 250 || !outer) return {1'b0, ref_c};
        if (win_blank) return {1'b1, ref_c};
        if (!pic) begin
            case (frame_sel)
                3'b000: return {1'b1, 6'd0, 6'd32, 6'd32};
                3'b001: return {1'b1, 6'd44, 6'd32, 6'd32};
                3'b100: return {1'b1, 6'd18, 6'd56, 6'd28};
                3'b101: return {1'b1, 6'd36, 6'd12, 6'd10};
                3'b110: return {1'b1, 6'd20, 6'd22, 6'd56};
                3'b111: return {1'b1, 6'd63, 6'd32, 6'd32};
                default: return {1'b0, ref_c};
            endcase
        end
        case (fill_sel)
            2'b01: return {1'b1, 6'd36, 6'd12, 6'd10};
            2'b10: return {1'b1, 6'd18, 6'd56, 6'd28};
            2'b11: return {1'b1, 6'd20, 6'd22, 6'd56};
            default: return {1'b1, mem_y, mem_u, mem_v};
        endcase
    endfunction

    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] act;
        act = {win_active, out_y, out_u, out_v};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pix=%0d line=%0d actual=%h expected=%h", req, pix_cnt, line_cnt, act, exp);
        end
    endtask

    // apply current inputs, advance one edge, compare
    task automatic step(input string req);
        logic [18:0] exp;
        exp = model();
        @(posedge clk);
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic at(input int px, input int ln, input string req);
        pix_cnt = 10'(px); line_cnt = 8'(ln);
        step(req);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        // R1 reset state
        x_code = 6'd10; y_code = 6'd10; win_enable = 1'b1; size_large = 1'b1;
        pix_cnt = 10'd130; line_cnt = 8'd50;
        repeat (3) @(negedge clk);
        check("R1", {1'b0, 6'd0, 6'd32, 6'd32});
        rst_n = 1'b1;
        @(negedge clk);
        mem_y = 6'd7; mem_u = 6'd9; mem_v = 6'd11;
        // R2 / R3 large size edges: xs=120 ys=40
        at(126, 45, "R2");
        at(122, 45, "R3"); at(123, 45, "R3"); at(239, 45, "R3"); at(240, 45, "R3");
        at(236, 45, "R3"); at(237, 45, "R3");
        at(130, 41, "R3"); at(130, 42, "R3"); at(130, 112, "R3"); at(130, 114, "R3"); at(130, 115, "R3");
        // R4 start corner and just before
        at(120, 40, "R4"); at(119, 40, "R4"); at(120, 39, "R4");
        // R3 small size
        size_large = 1'b0;
        at(206, 100, "R3"); at(209, 100, "R3"); at(210, 100, "R3"); at(130, 96, "R3"); at(130, 97, "R3");
        // R5 / R6 palette
        for (int c = 0; c < 8; c++) begin
            frame_sel = 3'(c);
            at(121, 60, (c == 2 || c == 3) ? "R6" : "R5");
        end
        // R7 fills
        frame_sel = 3'b111;
        for (int f = 0; f < 4; f++) begin
            fill_sel = 2'(f);
            at(150, 60, "R7");
        end
        // R8 blank over fill, frame and transparent frame
        win_blank = 1'b1;
        at(150, 60, "R8"); frame_sel = 3'b010; at(121, 60, "R8"); at(119, 60, "R8");
        win_blank = 1'b0; fill_sel = 2'b00;
        // R9 enable off
        win_enable = 1'b0; at(150, 60, "R9"); win_enable = 1'b1;
        // R11 cutoff limits, large size
        size_large = 1'b1; frame_sel = 3'b111;
        x_code = 6'd50; at(610, 60, "R11");
        x_code = 6'd51; at(622, 60, "R11");
        x_code = 6'd10; y_code = 6'd43; at(130, 180, "R11");
        y_code = 6'd44; at(130, 184, "R11");
        // random, biased to edges
        for (int i = 0; i < 3000; i++) begin
            int xs, ys;
            x_code = 6'($urandom_range(0, 63)); y_code = 6'($urandom_range(0, 63));
            size_large = 1'($urandom); win_enable = ($urandom_range(0, 9) != 0);
            win_blank = ($urandom_range(0, 7) == 0);
            frame_sel = 3'($urandom); fill_sel = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            mem_y = 6'($urandom); mem_u = 6'($urandom); mem_v = 6'($urandom);
            xs = x_code * 12; ys = y_code * 4;
            pix_cnt  = 10'((xs + $urandom_range(0, 130) - 4) % 768);
            line_cnt = 8'((ys + $urandom_range(0, 82) - 3) % 256);
            step((i % 2 == 0) ? "R10" : "R3");
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule